// File: doc/BRIEF.md
# Ramping Two-Digit Hex Display Peripheral

This peripheral sits on an 8-bit processor bus and drives a two-digit multiplexed seven-segment display. Software writes a target byte into the block. The byte the display shows is held in a separate count register, and that register does not jump to the new value. On each rising edge of a slow move clock the count takes one step of one unit toward the target. A bus read returns the count, so repeated reads let software watch the display converge.

The step direction comes from bit 7 of the 8-bit wrapped difference `target - count`. It does not come from a magnitude comparison. As a result, a gap of 128 or more is covered by counting down through the 0x00/0xFF wrap. External logic multiplexes the two digits through a digit-select input. The block places the selected nibble on active-low segment outputs, using hexadecimal glyphs, and raises the matching digit-enable output.

The bus strobes and the move clock are asynchronous to the system clock. Each one passes through a synchronizer and an edge detector, so every internal register runs on the single clock `clk`.

Top module: `ramp_hex_display`

## Requirements
- R1: A write is recognised only while `bus_cs_n` and `bus_wr_n` are both low. The byte on `data_io` is stored as the target once per such assertion, on the clock after the synchronised combined strobe rises. The target is stored within `SYNC_STAGES`+2 clocks of the strobe falling. A write strobe without chip select stores nothing.
- R2: `data_io` is driven only while `bus_cs_n` and `bus_rd_n` are both low, after `SYNC_STAGES` clocks of synchronisation. At all other times it is high impedance.
- R3: When `rst_n` is low at a rising `clk` edge, both the target and the count are cleared to 0x00. The clear is synchronous.
- R4: On each synchronised rising edge of `step_clk`, the block computes d = (target - count) mod 256. If d is 0 the count holds. If bit 7 of d is 0 the count increments by one. The count never changes at any other time.
- R5: If d is 128 or more, the count decrements, wrapping from 0x00 to 0xFF when needed. For example, count 0x00 with target 0x80 steps to 0xFF.
- R6: A bus read returns the current count, not the target.
- R7: When `digit_sel` is 0, the low nibble of the count goes to the decoder, `digit_a_en` is 1 and `digit_b_en` is 0. When `digit_sel` is 1, the high nibble goes to the decoder, `digit_b_en` is 1 and `digit_a_en` is 0.
- R8: `seg_n` is the bitwise inverse of the active-high glyph, with segment a on bit 0 through segment g on bit 6. The glyphs for nibbles 0 to F are 3F 06 5B 4F 66 6D 7D 07 7F 6F 77 7C 39 5E 79 71 (hex). When `dec_en` is 0, `seg_n` is 7F (all segments off).
- R9: A write made during a ramp replaces the target immediately. The next step moves from the current count toward the new target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_wr_n | input | 1 | Write strobe, active low |
| data_io | inout | 8 | Bidirectional data bus |
| step_clk | input | 1 | Move clock; each rising edge allows one step |
| digit_sel | input | 1 | Digit select: 0 = low nibble, 1 = high nibble |
| dec_en | input | 1 | Segment decoder enable, active high |
| digit_a_en | output | 1 | Enable for the low-nibble digit |
| digit_b_en | output | 1 | Enable for the high-nibble digit |
| seg_n | output | 7 | Active-low segments a..g on bits 0..6 |

## Verification
The assertions check the following on every clock:
- the count moves by at most one per clock, and only after a synchronised move edge;
- the count holds once it equals the target;
- a wrapped difference of 128 or more always steps down;
- exactly one digit enable is high;
- a disabled decoder blanks every segment;
- a driven bus carries the count.

Some behaviour shows only in the bench's scenarios. These are: writes being ignored without chip select; the bus staying released in the idle and half-selected states; the reset clearing the target as well as the count; retargeting in the middle of a ramp; and the exact glyph drawn for each nibble.

// File: rtl/ramp_disp_pkg.sv
// Package: shared widths for the ramping hex display.
// Assumes two hexadecimal digits packed into one byte.
package ramp_disp_pkg;
    localparam int DATA_W   = 8;
    localparam int NIBBLE_W = 4;
    localparam int SEG_W    = 7;
    localparam int DIGITS   = DATA_W / NIBBLE_W;

    typedef logic [DATA_W-1:0]   byte_t;
    typedef logic [NIBBLE_W-1:0] nibble_t;
    typedef logic [SEG_W-1:0]    seg_t;
endpackage

// File: rtl/edge_sync.sv
// Module: edge_sync
// Brings WIDTH asynchronous level signals into the clk domain through a
// STAGES-deep flop chain, then reports each synchronised level and a
// one-clock pulse on every rising edge of that level.
// Assumes STAGES >= 2 and inputs that hold each level for several clocks.
module edge_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] level_o,
    output logic [WIDTH-1:0] rise_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] chain_q;
    logic [WIDTH-1:0]             prev_q;

    // Purpose: shift the raw inputs through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            for (int s = STAGES - 1; s > 0; s--) begin
                chain_q[s] <= chain_q[s-1];
            end
            chain_q[0] <= async_in;
        end
    end

    // Purpose: remember the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= chain_q[LAST];
    end

    // Purpose: one edge detector per synchronised bit.
    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_edge
            assign level_o[b] = chain_q[LAST][b];
            assign rise_o[b]  = chain_q[LAST][b] & ~prev_q[b];
        end
    endgenerate
endmodule

// File: rtl/bus_port.sv
// Module: bus_port
// Holds the target register loaded by bus writes and produces the
// data-bus output enable for reads.
// Assumes wr_pulse is a single-clock pulse and the data bus is stable
// while the write strobe is held.
module bus_port
    import ramp_disp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_pulse,
    input  logic  rd_level,
    input  byte_t bus_in,
    output byte_t target_o,
    output logic  drive_o
);
    byte_t target_q;
    logic  drive_q;

    // Purpose: capture the bus byte once per recognised write.
    always_ff @(posedge clk) begin
        if (!rst_n)        target_q <= '0;
        else if (wr_pulse) target_q <= bus_in;
    end

    // Purpose: register the output enable so the bus turns around cleanly.
    always_ff @(posedge clk) begin
        if (!rst_n) drive_q <= 1'b0;
        else        drive_q <= rd_level;
    end

    assign target_o = target_q;
    assign drive_o  = drive_q;
endmodule

// File: rtl/ramp_counter.sv
// Module: ramp_counter
// Moves the displayed count one unit toward the target per step pulse.
// The direction is bit 7 of the wrapped difference target - count, so a
// gap of half the range or more is closed downward through the wrap.
// Assumes step is a single-clock pulse.
module ramp_counter
    import ramp_disp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  step,
    input  byte_t target,
    output byte_t count_o
);
    byte_t count_q;
    byte_t gap;
    logic  go_down;
    logic  settled;

    // Purpose: wrapped difference and its sign bit pick the step direction.
    always_comb begin
        gap     = byte_t'(target - count_q);
        go_down = gap[DATA_W-1];
        settled = (gap == '0);
    end

    // Purpose: apply one step toward the target when allowed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (step && !settled) begin
            if (go_down) count_q <= byte_t'(count_q - 1'b1);
            else         count_q <= byte_t'(count_q + 1'b1);
        end
    end

    assign count_o = count_q;
endmodule

// File: rtl/digit_select.sv
// Module: digit_select
// Picks one nibble of the count for the shared decoder and raises the
// enable of the digit that shows it (digit A = low nibble).
// Assumes exactly two digits.
module digit_select
    import ramp_disp_pkg::*;
(
    input  byte_t   value,
    input  logic    sel,
    output nibble_t nibble_o,
    output logic    a_en_o,
    output logic    b_en_o
);
    // Purpose: multiplex the nibble and decode the digit enable.
    always_comb begin
        nibble_o = sel ? value[DATA_W-1:NIBBLE_W] : value[NIBBLE_W-1:0];
        a_en_o   = ~sel;
        b_en_o   = sel;
    end
endmodule

// File: rtl/hex_seg_decoder.sv
// Module: hex_seg_decoder
// Turns a nibble into an active-high hexadecimal glyph, with segment a on
// bit 0 through segment g on bit 6. Returns all zeros when disabled.
// Assumes a common seven-segment layout; inversion happens at the top.
module hex_seg_decoder
    import ramp_disp_pkg::*;
(
    input  nibble_t nibble,
    input  logic    enable,
    output seg_t    seg_on
);
    seg_t glyph;

    // Purpose: glyph lookup for 0-9 and A-F.
    always_comb begin
        unique case (nibble)
            4'h0: glyph = 7'h3F;
            4'h1: glyph = 7'h06;
            4'h2: glyph = 7'h5B;
            4'h3: glyph = 7'h4F;
            4'h4: glyph = 7'h66;
            4'h5: glyph = 7'h6D;
            4'h6: glyph = 7'h7D;
            4'h7: glyph = 7'h07;
            4'h8: glyph = 7'h7F;
            4'h9: glyph = 7'h6F;
            4'hA: glyph = 7'h77;
            4'hB: glyph = 7'h7C;
            4'hC: glyph = 7'h39;
            4'hD: glyph = 7'h5E;
            4'hE: glyph = 7'h79;
            default: glyph = 7'h71;
        endcase
    end

    // Purpose: blank the glyph when the decoder is disabled.
    assign seg_on = enable ? glyph : '0;
endmodule

// File: rtl/ramp_hex_display.sv
// Module: ramp_hex_display (top)
// Bus-mapped two-digit hex display whose shown value ramps toward a
// written target by one unit per move-clock edge. Reads return the
// shown value. Strobes and the move clock are synchronised into clk.
// Assumes the external bus holds data stable while the write strobe is low.
module ramp_hex_display
    import ramp_disp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_cs_n,
    input  logic       bus_rd_n,
    input  logic       bus_wr_n,
    inout  wire  [7:0] data_io,
    input  logic       step_clk,
    input  logic       digit_sel,
    input  logic       dec_en,
    output logic       digit_a_en,
    output logic       digit_b_en,
    output logic [6:0] seg_n
);
    localparam int IDX_WR   = 0;
    localparam int IDX_RD   = 1;
    localparam int IDX_STEP = 2;
    localparam int N_SYNC   = 3;

    logic [N_SYNC-1:0] raw_req;
    logic [N_SYNC-1:0] sync_level;
    logic [N_SYNC-1:0] sync_rise;
    logic              step_pulse;
    logic              rd_oe;
    byte_t             target_q;
    byte_t             count_q;
    nibble_t           shown_nibble;
    seg_t              seg_on;

    // Purpose: combine select and strobes into active-high requests.
    always_comb begin
        raw_req[IDX_WR]   = ~bus_cs_n & ~bus_wr_n;
        raw_req[IDX_RD]   = ~bus_cs_n & ~bus_rd_n;
        raw_req[IDX_STEP] = step_clk;
    end

    edge_sync #(.STAGES(SYNC_STAGES), .WIDTH(N_SYNC)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_req),
        .level_o  (sync_level),
        .rise_o   (sync_rise)
    );

    assign step_pulse = sync_rise[IDX_STEP];

    bus_port u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_pulse (sync_rise[IDX_WR]),
        .rd_level (sync_level[IDX_RD]),
        .bus_in   (data_io),
        .target_o (target_q),
        .drive_o  (rd_oe)
    );

    ramp_counter u_ramp (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (step_pulse),
        .target  (target_q),
        .count_o (count_q)
    );

    digit_select u_dsel (
        .value    (count_q),
        .sel      (digit_sel),
        .nibble_o (shown_nibble),
        .a_en_o   (digit_a_en),
        .b_en_o   (digit_b_en)
    );

    hex_seg_decoder u_dec (
        .nibble (shown_nibble),
        .enable (dec_en),
        .seg_on (seg_on)
    );

    // Purpose: segments are active low at the pins.
    assign seg_n   = ~seg_on;
    // Purpose: release the bus except during a recognised read.
    assign data_io = rd_oe ? count_q : 8'hzz;
endmodule

// File: rtl/ramp_hex_display_chk.sv
// Module: ramp_hex_display_chk
// Cycle-level properties of the ramping display, bound into the top.
module ramp_hex_display_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       step_pulse,
    input logic       rd_oe,
    input logic [7:0] count_q,
    input logic [7:0] target_q,
    input logic [7:0] data_io,
    input logic       dec_en,
    input logic       digit_a_en,
    input logic       digit_b_en,
    input logic [6:0] seg_n
);
    logic [7:0] gap;
    assign gap = 8'(target_q - count_q);

    AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(count_q) |-> (count_q == 8'($past(count_q) + 8'd1)) || (count_q == 8'($past(count_q) - 8'd1))); // R4
    AST_MOVE_ONLY_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !step_pulse |=> $stable(count_q)); // R4
    AST_HOLD_AT_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == target_q) |=> $stable(count_q)); // R4
    AST_WRAP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (step_pulse && gap >= 8'd128) |=> (count_q == 8'($past(count_q) - 8'd1))); // R5
    AST_BUS_SHOWS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_oe |-> (data_io == count_q)); // R6
    AST_ONE_DIGIT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({digit_a_en, digit_b_en}) == 1); // R7
    AST_BLANK_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_en |-> (seg_n == 7'h7F)); // R8
endmodule

bind ramp_hex_display ramp_hex_display_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_pulse (step_pulse),
    .rd_oe      (rd_oe),
    .count_q    (count_q),
    .target_q   (target_q),
    .data_io    (data_io),
    .dec_en     (dec_en),
    .digit_a_en (digit_a_en),
    .digit_b_en (digit_b_en),
    .seg_n      (seg_n)
);

// File: tb/tb_ramp_hex_display.sv
module tb_ramp_hex_display;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic       step_clk = 1'b0, digit_sel = 1'b0, dec_en = 1'b1;
    logic       a_en, b_en;
    logic [6:0] seg_n;
    logic       tb_drv = 1'b0;
    logic [7:0] tb_val = 8'h00;
    tri1  [7:0] data_bus;

    int checks = 0, fails = 0;
    bit done = 0;
    logic [7:0] m_cnt = 8'h00, m_tgt = 8'h00;

    assign data_bus = tb_drv ? tb_val : 8'hzz;
    always #5 clk = ~clk;

    ramp_hex_display dut (
        .clk(clk), .rst_n(rst_n), .bus_cs_n(cs_n), .bus_rd_n(rd_n),
        .bus_wr_n(wr_n), .data_io(data_bus), .step_clk(step_clk),
        .digit_sel(digit_sel), .dec_en(dec_en), .digit_a_en(a_en),
        .digit_b_en(b_en), .seg_n(seg_n)
    );

    function automatic logic [6:0] glyph(input logic [3:0] n);
        case (n)
            4'h0: return 7'h3F; 4'h1: return 7'h06; 4'h2: return 7'h5B; 4'h3: return 7'h4F;
            4'h4: return 7'h66; 4'h5: return 7'h6D; 4'h6: return 7'h7D; 4'h7: return 7'h07;
            4'h8: return 7'h7F; 4'h9: return 7'h6F; 4'hA: return 7'h77; 4'hB: return 7'h7C;
            4'hC: return 7'h39; 4'hD: return 7'h5E; 4'hE: return 7'h79; default: return 7'h71;
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [7:0] v);
        tb_val = v; tb_drv = 1'b1; cs_n = 1'b0; wr_n = 1'b0;
        cycles(5);
        cs_n = 1'b1; wr_n = 1'b1;
        cycles(2);
        tb_drv = 1'b0;
        cycles(2);
        m_tgt = v;
    endtask

    task automatic bus_read(output logic [7:0] v);
        cs_n = 1'b0; rd_n = 1'b0;
        cycles(4);
        v = data_bus;
        cs_n = 1'b1; rd_n = 1'b1;
        cycles(4);
    endtask

    // One move-clock pulse, model step, then read back and compare.
    task automatic step_and_check();
        logic [7:0] d, got;
        d = 8'(m_tgt - m_cnt);
        step_clk = 1'b1; cycles(4);
        step_clk = 1'b0; cycles(4);
        if (d != 8'h00) m_cnt = d[7] ? 8'(m_cnt - 1) : 8'(m_cnt + 1);
        bus_read(got);
        if (d[7]) check("R5 wrapped step down", got, m_cnt);
        else      check("R4 step toward target", got, m_cnt);
    endtask

    task automatic ramp_to(input logic [7:0] t);
        bus_write(t);
        for (int i = 0; i < 300 && m_cnt != t; i++) step_and_check();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] got;
        cycles(4);
        rst_n = 1'b1;
        cycles(2);

        // R3 / R6: count is zero after reset
        bus_read(got); check("R3 count after reset", got, 8'h00);

        // R6: read gives count, not the freshly written target
        bus_write(8'h05);
        bus_read(got); check("R6 read returns count", got, 8'h00);
        step_and_check();

        // R2: bus released when not both select and read are low
        cs_n = 1'b1; rd_n = 1'b0; cycles(5);
        check("R2 released without select", data_bus, 8'hFF);
        rd_n = 1'b1; cycles(2);
        cs_n = 1'b0; cycles(5);
        check("R2 released without read", data_bus, 8'hFF);
        cs_n = 1'b1; cycles(3);

        // R1: write strobe without chip select stores nothing
        tb_val = 8'h80; tb_drv = 1'b1; wr_n = 1'b0; cycles(5);
        wr_n = 1'b1; cycles(2); tb_drv = 1'b0; cycles(2);
        step_and_check();   // still heads up to 0x05, not down toward 0x80
        check("R1 no write without select", m_cnt, 8'h02);

        // R4: reach target then hold
        ramp_to(8'h05);
        step_and_check(); step_and_check();
        check("R4 hold at target", m_cnt, 8'h05);

        // R3: reset clears count and target
        rst_n = 1'b0; cycles(3); rst_n = 1'b1; cycles(2);
        m_cnt = 8'h00; m_tgt = 8'h00;
        bus_read(got); check("R3 count cleared", got, 8'h00);
        step_and_check();   // target cleared too: count stays 0

        // R5: half-range gap goes down through the wrap
        bus_write(8'h80); step_and_check();
        check("R5 0x00 toward 0x80 gives 0xFF", m_cnt, 8'hFF);
        bus_write(8'h7F); step_and_check();

        // R4 / R5: one step toward every possible target
        for (int t = 0; t < 256; t++) begin
            bus_write(8'(t)); step_and_check();
        end

        // R9: full ramps with retargeting in the middle
        for (int k = 0; k < 12; k++) begin
            bus_write(8'((k * 53 + 7) & 255));
            for (int i = 0; i < 3; i++) step_and_check();
            if (k % 2 == 1) begin
                bus_write(8'((k * 29 + 100) & 255));
                step_and_check();   // R9: next step heads to the new target
            end
            ramp_to(m_tgt);
        end

        // R7 / R8: every nibble on both digits, then blanking
        for (int k = 0; k < 16; k++) begin
            logic [7:0] v;
            v = {4'(k), 4'(15 - k)};
            ramp_to(v);
            digit_sel = 1'b0; cycles(1);
            check("R7 digit A enable", {7'd0, a_en}, 8'h01);
            check("R8 low nibble glyph", {1'b0, seg_n}, {1'b0, ~glyph(4'(15 - k))});
            digit_sel = 1'b1; cycles(1);
            check("R7 digit B enable", {7'd0, b_en}, 8'h01);
            check("R8 high nibble glyph", {1'b0, seg_n}, {1'b0, ~glyph(4'(k))});
            dec_en = 1'b0; cycles(1);
            check("R8 decoder disabled", {1'b0, seg_n}, 8'h7F);
            dec_en = 1'b1; digit_sel = 1'b0; cycles(1);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule